// File: doc/BRIEF.md
# Associative Page Translation Unit

This unit turns a word address into a physical core address. The upper address bits form a block number. That block number is compared at the same time against the block-number register of every core page. Each page also has a lock-out bit. When exactly one page holds the block and access is allowed, the unit returns that page's index, and the word offset is passed through unchanged.

A request that finds no page raises a translation fault. The unit also faults when the matching page is locked, or when the block number lies in the reserved supervisor range, unless the request runs in privileged mode. With a fault, the unit reports the offending block number so that a handler can service the miss.

Supervisor software fills the page registers through a small indexed write/read port. A transfer channel finds its own page by looking up a dedicated dummy block number in privileged mode. That page stays locked against ordinary programs while the channel uses it. Results are registered and appear one cycle after the request.

Top module: `page_xlate_unit`

## Requirements
- R1: While reset is high and in the first cycle after it, every page register reads back as lock = 1 and block = 0, and all response outputs are 0.
- R2: On a hit, `rsp_phys` equals {page index, low 9 request address bits}: the offset is untranslated. On a fault, `rsp_phys` and `rsp_page` are 0.
- R3: The response fields describe the request presented at the previous clock edge. `rsp_valid` is `req_valid` delayed by one cycle. With `rsp_valid` low, every other response output is 0.
- R4: When no page register holds the requested block number (address bits 19:9), `rsp_fault` is 1 and `rsp_hit` is 0.
- R5: A request that matches a page with lock = 1 faults when `req_priv` is 0, and hits when `req_priv` is 1.
- R6: A request whose block number is 1792 or higher (the top 256 values) faults when `req_priv` is 0, even if a page holds it unlocked. A privileged request for such a block hits.
- R7: When several pages hold the requested block, the lowest page index is used and `rsp_multi` is 1. With zero or one match, `rsp_multi` is 0.
- R8: `rsp_fault_blk` equals the requested block number when `rsp_fault` is 1, and is 0 otherwise.
- R9: When `cfg_we` is 1, page `cfg_idx` is loaded from `cfg_wdata` (bit 11 = lock, bits 10:0 = block). `cfg_rdata` shows page `cfg_idx` in the same encoding at all times.
- R10: A register write and a lookup at the same edge: the lookup uses the old contents, and the new contents apply from the next request onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | 20 | Word address: block number [19:9], offset [8:0] |
| req_priv | input | 1 | Privileged (interrupt-control) request |
| cfg_we | input | 1 | Page register write enable |
| cfg_idx | input | 5 | Page register index for write and read |
| cfg_wdata | input | 12 | Write data: lock [11], block [10:0] |
| cfg_rdata | output | 12 | Read data of page `cfg_idx` |
| rsp_valid | output | 1 | Response valid |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_page | output | 5 | Matching page index on a hit |
| rsp_phys | output | 14 | Physical word address on a hit |
| rsp_fault | output | 1 | Translation fault interrupt |
| rsp_fault_blk | output | 11 | Block number that faulted |
| rsp_multi | output | 1 | More than one page matched |

## Verification
The bench loads the same block into several pages and checks that the lowest index wins with the multi flag set. A design that took the highest index, or dropped the flag, would return the wrong page. It also looks up locked pages and reserved block numbers with and without privilege. A design that ignored the privilege bypass would fault channel lookups, and one that ignored the lock or the reserved range would let ordinary programs reach supervisor pages. Writes in the same cycle as a lookup of the rewritten page show whether the new contents leak in one cycle early. A long pseudo-random phase, checked against a behavioural model every cycle, looks for stale matches, bad offsets and fault block numbers left non-zero.

// File: rtl/pxl_pkg.sv
package pxl_pkg;
    localparam int WORD_BITS  = 9;
    localparam int BLK_BITS   = 11;
    localparam int RSV_COUNT  = 256;
    localparam int ADDR_BITS  = BLK_BITS + WORD_BITS;
    localparam int RSV_BASE   = (1 << BLK_BITS) - RSV_COUNT;
    localparam int ENTRY_BITS = BLK_BITS + 1;

    typedef struct packed {
        logic                lock;
        logic [BLK_BITS-1:0] blk;
    } page_reg_t;

    function automatic logic [BLK_BITS-1:0] blk_of(input logic [ADDR_BITS-1:0] a);
        return a[ADDR_BITS-1:WORD_BITS];
    endfunction

    function automatic logic [WORD_BITS-1:0] off_of(input logic [ADDR_BITS-1:0] a);
        return a[WORD_BITS-1:0];
    endfunction

    function automatic logic is_reserved(input logic [BLK_BITS-1:0] b);
        return 32'(b) >= RSV_BASE;
    endfunction
endpackage

// File: rtl/pxl_regfile.sv
module pxl_regfile
    import pxl_pkg::*;
#(
    parameter int N_PAGES = 32,
    localparam int IDX_W  = $clog2(N_PAGES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  page_reg_t        wdata,
    output page_reg_t        rdata,
    output page_reg_t        regs [N_PAGES]
);
    for (genvar g = 0; g < N_PAGES; g++) begin : g_page
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[g] <= '{lock: 1'b1, blk: '0};
            end else if (we && (idx == IDX_W'(g))) begin
                regs[g] <= wdata;
            end
        end
    end

    assign rdata = regs[idx];
endmodule

// File: rtl/pxl_cam_match.sv
module pxl_cam_match
    import pxl_pkg::*;
#(
    parameter int N_PAGES = 32
) (
    input  page_reg_t           regs [N_PAGES],
    input  logic [BLK_BITS-1:0] key,
    output logic [N_PAGES-1:0]  match,
    output logic [N_PAGES-1:0]  locked
);
    for (genvar g = 0; g < N_PAGES; g++) begin : g_cmp
        assign match[g]  = (regs[g].blk == key);
        assign locked[g] = regs[g].lock;
    end
endmodule

// File: rtl/pxl_prio_enc.sv
module pxl_prio_enc #(
    parameter int N_PAGES = 32,
    localparam int IDX_W  = $clog2(N_PAGES)
) (
    input  logic [N_PAGES-1:0] vec,
    output logic               any,
    output logic               multi,
    output logic [IDX_W-1:0]   idx
);
    always_comb begin
        any   = 1'b0;
        multi = 1'b0;
        idx   = '0;
        for (int i = 0; i < N_PAGES; i++) begin
            if (vec[i]) begin
                if (any) begin
                    multi = 1'b1;
                end else begin
                    idx = IDX_W'(i);
                end
                any = 1'b1;
            end
        end
    end
endmodule

// File: rtl/page_xlate_unit.sv
module page_xlate_unit
    import pxl_pkg::*;
#(
    parameter int N_PAGES = 32,
    localparam int IDX_W  = $clog2(N_PAGES),
    localparam int PHYS_W = IDX_W + WORD_BITS
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    input  logic [ADDR_BITS-1:0]  req_addr,
    input  logic                  req_priv,
    input  logic                  cfg_we,
    input  logic [IDX_W-1:0]      cfg_idx,
    input  logic [ENTRY_BITS-1:0] cfg_wdata,
    output logic [ENTRY_BITS-1:0] cfg_rdata,
    output logic                  rsp_valid,
    output logic                  rsp_hit,
    output logic [IDX_W-1:0]      rsp_page,
    output logic [PHYS_W-1:0]     rsp_phys,
    output logic                  rsp_fault,
    output logic [BLK_BITS-1:0]   rsp_fault_blk,
    output logic                  rsp_multi
);
    page_reg_t           regs [N_PAGES];
    page_reg_t           rd_ent;
    logic [N_PAGES-1:0]  match_v;
    logic [N_PAGES-1:0]  lock_v;
    logic                any_m, multi_m;
    logic [IDX_W-1:0]    win_idx;
    logic [BLK_BITS-1:0] key;
    logic                allow, hit_c;

    pxl_regfile #(.N_PAGES(N_PAGES)) u_regs (
        .clk(clk), .rst(rst), .we(cfg_we), .idx(cfg_idx),
        .wdata(page_reg_t'(cfg_wdata)), .rdata(rd_ent), .regs(regs)
    );

    assign key = blk_of(req_addr);

    pxl_cam_match #(.N_PAGES(N_PAGES)) u_cam (
        .regs(regs), .key(key), .match(match_v), .locked(lock_v)
    );

    pxl_prio_enc #(.N_PAGES(N_PAGES)) u_enc (
        .vec(match_v), .any(any_m), .multi(multi_m), .idx(win_idx)
    );

    assign cfg_rdata = ENTRY_BITS'(rd_ent);
    assign allow     = req_priv || (!lock_v[win_idx] && !is_reserved(key));
    assign hit_c     = any_m && allow;

    always_ff @(posedge clk) begin
        if (rst || !req_valid) begin
            rsp_valid     <= 1'b0;
            rsp_hit       <= 1'b0;
            rsp_page      <= '0;
            rsp_phys      <= '0;
            rsp_fault     <= 1'b0;
            rsp_fault_blk <= '0;
            rsp_multi     <= 1'b0;
        end else begin
            rsp_valid     <= 1'b1;
            rsp_hit       <= hit_c;
            rsp_page      <= hit_c ? win_idx : '0;
            rsp_phys      <= hit_c ? {win_idx, off_of(req_addr)} : '0;
            rsp_fault     <= !hit_c;
            rsp_fault_blk <= hit_c ? '0 : key;
            rsp_multi     <= multi_m;
        end
    end
endmodule

// File: rtl/pxl_checker.sv
module pxl_checker
    import pxl_pkg::*;
#(
    parameter int N_PAGES = 32,
    localparam int IDX_W  = $clog2(N_PAGES),
    localparam int PHYS_W = IDX_W + WORD_BITS
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  req_valid,
    input logic [ADDR_BITS-1:0]  req_addr,
    input logic                  req_priv,
    input logic                  cfg_we,
    input logic [IDX_W-1:0]      cfg_idx,
    input logic [ENTRY_BITS-1:0] cfg_wdata,
    input logic [ENTRY_BITS-1:0] cfg_rdata,
    input logic                  rsp_valid,
    input logic                  rsp_hit,
    input logic [PHYS_W-1:0]     rsp_phys,
    input logic                  rsp_fault,
    input logic [BLK_BITS-1:0]   rsp_fault_blk,
    input logic                  rsp_multi
);
    assert_valid_delay_R3: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> !(rsp_hit || rsp_fault || rsp_multi));
    assert_hit_xor_fault_R4: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_hit != rsp_fault));
    assert_offset_pass_R2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !rst) |=> (!rsp_hit || rsp_phys[WORD_BITS-1:0] == $past(req_addr[WORD_BITS-1:0])));
    assert_reserved_fault_R6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_priv && is_reserved(blk_of(req_addr))) |=> rsp_fault);
    assert_fault_blk_R8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !rst) |=> (rsp_fault_blk == (rsp_fault ? $past(blk_of(req_addr)) : '0)));
    assert_write_lands_R9: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> ((cfg_idx != $past(cfg_idx)) || (cfg_rdata == $past(cfg_wdata))));
endmodule

bind page_xlate_unit pxl_checker #(.N_PAGES(N_PAGES)) u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_priv(req_priv), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .rsp_phys(rsp_phys), .rsp_fault(rsp_fault),
    .rsp_fault_blk(rsp_fault_blk), .rsp_multi(rsp_multi)
);

// File: tb/tb_page_xlate_unit.sv
`timescale 1ns/1ps
module tb_page_xlate_unit;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [19:0] req_addr = '0;
    logic        req_priv = 1'b0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_idx = '0;
    logic [11:0] cfg_wdata = '0;
    logic [11:0] cfg_rdata;
    logic        rsp_valid, rsp_hit, rsp_fault, rsp_multi;
    logic [4:0]  rsp_page;
    logic [13:0] rsp_phys;
    logic [10:0] rsp_fault_blk;

    int checks = 0;
    int errors = 0;
    int cyc_cnt = 0;

    logic [11:0] m_tab [NP];
    logic        e_valid, e_hit, e_fault, e_multi;
    logic [4:0]  e_page;
    logic [13:0] e_phys;
    logic [10:0] e_fblk;
    logic        in_reset = 1'b1;

    page_xlate_unit dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_priv(req_priv), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .rsp_valid(rsp_valid),
        .rsp_hit(rsp_hit), .rsp_page(rsp_page), .rsp_phys(rsp_phys),
        .rsp_fault(rsp_fault), .rsp_fault_blk(rsp_fault_blk), .rsp_multi(rsp_multi)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural reference: table lookup evaluated before the write is applied.
    always @(posedge clk) begin
        cyc_cnt++;
        if (rst) begin
            for (int i = 0; i < NP; i++) m_tab[i] = 12'h800;
            {e_valid, e_hit, e_fault, e_multi} = '0;
            e_page = '0; e_phys = '0; e_fblk = '0;
            in_reset = 1'b1;
        end else begin
            int first;
            int nmatch;
            logic ok;
            in_reset = 1'b0;
            first = -1;
            nmatch = 0;
            for (int i = 0; i < NP; i++) begin
                if (m_tab[i][10:0] == req_addr[19:9]) begin
                    nmatch++;
                    if (first < 0) first = i;
                end
            end
            ok = (first >= 0) &&
                 (req_priv || (!m_tab[first][11] && (int'(req_addr[19:9]) < 1792)));
            e_valid = req_valid;
            e_hit   = req_valid && ok;
            e_fault = req_valid && !ok;
            e_multi = req_valid && (nmatch > 1);
            e_page  = e_hit ? 5'(first) : '0;
            e_phys  = e_hit ? {5'(first), req_addr[8:0]} : '0;
            e_fblk  = e_fault ? req_addr[19:9] : '0;
            if (cfg_we) m_tab[cfg_idx] = cfg_wdata;
        end
    end

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc_cnt);
        end
    endtask

    always @(negedge clk) begin
        if (cyc_cnt > 0) begin
            chk(rsp_valid == e_valid, in_reset ? "R1 valid" : "R3 valid", rsp_valid, e_valid);
            chk(rsp_hit == e_hit, "R4/R5 hit", rsp_hit, e_hit);
            chk(rsp_fault == e_fault, "R4/R5/R6 fault", rsp_fault, e_fault);
            chk(rsp_page == e_page, "R7 page", rsp_page, e_page);
            chk(rsp_phys == e_phys, "R2 phys", rsp_phys, e_phys);
            chk(rsp_multi == e_multi, "R7 multi", rsp_multi, e_multi);
            chk(rsp_fault_blk == e_fblk, "R8 fault_blk", rsp_fault_blk, e_fblk);
            chk(cfg_rdata == m_tab[cfg_idx], "R9 cfg_rdata", cfg_rdata, m_tab[cfg_idx]);
        end
    end

    task automatic step(input logic v, input logic [10:0] b, input logic [8:0] o, input logic p,
                        input logic we, input logic [4:0] ix, input logic [11:0] wd);
        @(negedge clk); #1;
        req_valid = v; req_addr = {b, o}; req_priv = p;
        cfg_we = we; cfg_idx = ix; cfg_wdata = wd;
    endtask

    task automatic wr(input logic [4:0] ix, input logic lk, input logic [10:0] b);
        step(1'b0, '0, '0, 1'b0, 1'b1, ix, {lk, b});
    endtask

    task automatic look(input logic [10:0] b, input logic [8:0] o, input logic p);
        step(1'b1, b, o, p, 1'b0, 5'd0, '0);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(negedge clk);
        // R1: register readback during reset
        for (int i = 0; i < NP; i++) begin
            cfg_idx = 5'(i);
            #1;
            chk(cfg_rdata == 12'h800, "R1 reset entry", cfg_rdata, 12'h800);
        end
        @(negedge clk); #1; rst = 1'b0;
        // R1: a request right after reset finds locked block 0 pages only
        look(11'd0, 9'd5, 1'b0);
        look(11'd0, 9'd6, 1'b1);  // privileged: lowest index, multi (R7, R5)
        for (int i = 0; i < NP; i++) wr(5'(i), 1'b0, 11'(100 + i));
        look(11'd105, 9'h1FF, 1'b0);  // R2 offset boundary
        look(11'd131, 9'h000, 1'b0);  // last page
        look(11'd99, 9'd7, 1'b0);     // R4 miss
        wr(5'd9, 1'b1, 11'd109);
        look(11'd109, 9'd3, 1'b0);    // R5 locked faults
        look(11'd109, 9'd3, 1'b1);    // R5 privileged hits
        wr(5'd20, 1'b1, 11'd2047);    // channel dummy block
        look(11'd2047, 9'd1, 1'b1);
        look(11'd2047, 9'd1, 1'b0);
        wr(5'd21, 1'b0, 11'd1792);    // R6 reserved boundary
        look(11'd1792, 9'd2, 1'b0);
        look(11'd1792, 9'd2, 1'b1);
        wr(5'd22, 1'b0, 11'd1791);
        look(11'd1791, 9'd2, 1'b0);
        wr(5'd30, 1'b0, 11'd200);     // R7 duplicates
        wr(5'd12, 1'b0, 11'd200);
        look(11'd200, 9'd4, 1'b0);
        // R10: write and lookup at the same edge
        step(1'b1, 11'd300, 9'd8, 1'b0, 1'b1, 5'd3, {1'b0, 11'd300});
        look(11'd300, 9'd8, 1'b0);
        step(1'b1, 11'd300, 9'd9, 1'b0, 1'b1, 5'd3, {1'b1, 11'd300});
        look(11'd300, 9'd9, 1'b0);
        // pseudo-random phase over a small block pool
        lfsr = 16'hACE1;
        for (int n = 0; n < 2000; n++) begin
            logic [10:0] b;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            b = lfsr[3] ? 11'(100 + lfsr[8:4]) : {lfsr[2], 5'b11111, lfsr[9:5]};
            step(lfsr[0] | lfsr[1], b, lfsr[15:7], lfsr[11], lfsr[14] & lfsr[6],
                 lfsr[12:8], {lfsr[2] & lfsr[5], b});
        end
        step(1'b0, '0, '0, 1'b0, 1'b0, 5'd0, '0);
        repeat (3) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule